// File: doc/BRIEF.md
# Partition Transpose and Shuffle Unit

This unit sits between a group of 32 memory partitions and 32 vector lanes and changes which partition each lane's data comes from. Input arrives as one beat per cycle: 32 elements side by side, one per partition, with a valid/ready handshake. Output leaves the same way. A mode input picks one of two reorderings.

In transpose mode the unit collects a tile of 32 beats and then emits it with the partition index and the free index swapped. Output beat k carries, on lane q, the element that partition k supplied on input beat q. Two tile stores alternate, so the next tile can fill while the previous one drains. In shuffle mode each output lane takes its element from a source partition chosen by a programmable mask. Each mask entry is reduced modulo 32. A single register stage sits between the input and the output in this mode.

A mode change waits until the unit holds no data. A mask written while a shuffle tile is in flight is applied from the first beat of the next 32-beat tile.

Top module: `prt_reorder_unit`

## Requirements
- R1: After reset the unit is in transpose mode with no data held: `out_valid` is 0 and `in_ready` is 1.
- R2: In transpose mode (`mode_req` = 0), output beat k of a tile carries on lane q the element that input beat q of the same tile carried on lane k, for all k and q in 0..31. Lane j of a beat sits at bits [32j+31:32j].
- R3: Two tile stores alternate. With `out_ready` held low, exactly 64 input beats are accepted in transpose mode before `in_ready` drops.
- R4: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged.
- R5: In shuffle mode (`mode_req` = 1), output lane i carries input lane (m[i] mod 32), where m[i] is the 8-bit mask entry at bits [8i+7:8i] of `mask_in`.
- R6: An all-zero mask broadcasts input lane 0 onto all 32 output lanes.
- R7: A mask with m[i] = i passes every lane straight through. Entries that differ by a multiple of 32 select the same source.
- R8: In shuffle mode a beat accepted at one clock edge is presented at the output right after that edge. With `out_ready` high, one beat is accepted every cycle.
- R9: A mask write (`mask_we` = 1) applies from the first beat of the next 32-beat shuffle tile. The remaining beats of a tile already in flight keep the mask that tile started with.
- R10: A `mode_req` differing from the current mode takes effect only once the unit holds no data. Until then `in_ready` is 0 and output of held data continues in the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_req | input | 1 | Requested mode: 0 transpose, 1 shuffle |
| mask_we | input | 1 | Load `mask_in` as the pending shuffle mask |
| mask_in | input | 256 | 32 mask entries of 8 bits, entry i at bits [8i+7:8i] |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit accepts the input beat |
| in_data | input | 1024 | 32 partition elements, lane j at bits [32j+31:32j] |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer accepts the output beat |
| out_data | output | 1024 | 32 lane elements, lane j at bits [32j+31:32j] |

## Verification
Each failure mode of the internal state shows up at the ports in a characteristic way. If a write or read counter slips, or a store is written into the wrong bank, the transposed rows become misplaced or mixed between tiles. This appears on the first beat of the affected tile and is caught by comparing every beat against an expected-value queue. If a bank's full flag goes wrong, the beat count at which `in_ready` falls under sustained back-pressure moves away from 64. If the mask is taken at the wrong point, the routing changes in the middle of a tile, one beat after the write. If the mode gate leaks, `in_ready` rises while old data is still being drained.

// File: rtl/prt_pkg.sv
// Shared types for the partition reorder unit.
// Assumes: mode is a single select bit driven from outside.
package prt_pkg;
    typedef enum logic {
        MODE_XPOSE = 1'b0,
        MODE_SHUF  = 1'b1
    } prt_mode_e;
endpackage

// File: rtl/prt_xpose_buf.sv
// Ping-pong tile store for transpose mode.
// Fills one bank over LANES beats, one column per beat, then drains it one
// row per beat while the other bank fills.
// Assumes LANES is a power of two.
module prt_xpose_buf #(
    parameter int LANES  = 32,
    parameter int ELEM_W = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES*ELEM_W-1:0] in_data,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [LANES*ELEM_W-1:0] out_data,
    output logic                    empty
);
    localparam int CW = $clog2(LANES);
    localparam logic [CW-1:0] LAST = CW'(LANES - 1);

    logic [ELEM_W-1:0] mem [2][LANES][LANES];
    logic [1:0]        full;
    logic              wr_bank, rd_bank;
    logic [CW-1:0]     wr_cnt, rd_cnt;
    logic              in_fire, out_fire, wr_last, rd_last;

    assign in_ready  = !full[wr_bank];
    assign out_valid = full[rd_bank];
    assign in_fire   = in_valid && in_ready;
    assign out_fire  = out_valid && out_ready;
    assign wr_last   = in_fire && (wr_cnt == LAST);
    assign rd_last   = out_fire && (rd_cnt == LAST);
    assign empty     = (full == 2'b00) && (wr_cnt == '0);

    // Advance the fill and drain pointers and track which banks are full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full    <= '0;
            wr_bank <= 1'b0;
            rd_bank <= 1'b0;
            wr_cnt  <= '0;
            rd_cnt  <= '0;
        end else begin
            if (in_fire) begin
                wr_cnt <= wr_last ? '0 : wr_cnt + CW'(1);
                if (wr_last) wr_bank <= !wr_bank;
            end
            if (out_fire) begin
                rd_cnt <= rd_last ? '0 : rd_cnt + CW'(1);
                if (rd_last) rd_bank <= !rd_bank;
            end
            for (int b = 0; b < 2; b++) begin
                if (wr_last && (wr_bank == b[0]))      full[b] <= 1'b1;
                else if (rd_last && (rd_bank == b[0])) full[b] <= 1'b0;
            end
        end
    end

    // Store each partition's element as column wr_cnt of the filling bank.
    always_ff @(posedge clk) begin
        if (in_fire) begin
            for (int p = 0; p < LANES; p++)
                mem[wr_bank][p][wr_cnt] <= in_data[p*ELEM_W +: ELEM_W];
        end
    end

    // Present row rd_cnt of the draining bank, lane q taking column q.
    for (genvar q = 0; q < LANES; q++) begin : g_rd
        assign out_data[q*ELEM_W +: ELEM_W] = mem[rd_bank][rd_cnt][q];
    end
endmodule

// File: rtl/prt_lane_shuffle.sv
// Mask-driven lane router for shuffle mode, with one registered output stage.
// The pending mask is latched as the active mask on the first beat of every
// LANES-beat tile. Assumes LANES is a power of two, so the low index bits
// give the modulo.
module prt_lane_shuffle #(
    parameter int LANES  = 32,
    parameter int ELEM_W = 32,
    parameter int MASK_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mask_we,
    input  logic [LANES*MASK_W-1:0] mask_in,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES*ELEM_W-1:0] in_data,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [LANES*ELEM_W-1:0] out_data,
    output logic                    empty
);
    localparam int CW = $clog2(LANES);
    localparam logic [CW-1:0] LAST = CW'(LANES - 1);

    logic [LANES*MASK_W-1:0] pend_mask, act_mask, eff_mask;
    logic [LANES*ELEM_W-1:0] routed;
    logic [CW-1:0]           beat_cnt;
    logic                    in_fire, tile_start;

    assign in_ready   = !out_valid || out_ready;
    assign in_fire    = in_valid && in_ready;
    assign tile_start = (beat_cnt == '0);
    assign eff_mask   = tile_start ? pend_mask : act_mask;
    assign empty      = !out_valid && tile_start;

    // Select the source partition of each output lane from the effective mask.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [CW-1:0] src;
        assign src = eff_mask[i*MASK_W +: CW];
        assign routed[i*ELEM_W +: ELEM_W] = in_data[int'(src)*ELEM_W +: ELEM_W];
    end

    // Hold the masks, count beats within a tile and keep the output valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_mask <= '0;
            act_mask  <= '0;
            beat_cnt  <= '0;
            out_valid <= 1'b0;
        end else begin
            if (mask_we) pend_mask <= mask_in;
            if (in_fire) begin
                beat_cnt <= (beat_cnt == LAST) ? '0 : beat_cnt + CW'(1);
                if (tile_start) act_mask <= pend_mask;
            end
            if (in_fire)        out_valid <= 1'b1;
            else if (out_ready) out_valid <= 1'b0;
        end
    end

    // Register the routed beat.
    always_ff @(posedge clk) begin
        if (!rst_n)       out_data <= '0;
        else if (in_fire) out_data <= routed;
    end
endmodule

// File: rtl/prt_reorder_unit.sv
// Partition transpose and shuffle unit, top level.
// Steers the handshake to the transpose store or the lane router according to
// the current mode. The mode follows mode_req only while both paths are empty.
// Assumes LANES is a power of two.
module prt_reorder_unit
    import prt_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int ELEM_W = 32,
    parameter int MASK_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    mode_req,
    input  logic                    mask_we,
    input  logic [LANES*MASK_W-1:0] mask_in,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES*ELEM_W-1:0] in_data,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [LANES*ELEM_W-1:0] out_data
);
    localparam int DW = LANES * ELEM_W;

    prt_mode_e         mode_q;
    logic              mode_ok, idle, is_shuf;
    logic              x_in_ready, x_out_valid, x_empty;
    logic              s_in_ready, s_out_valid, s_empty;
    logic [DW-1:0]     x_out_data, s_out_data;

    assign mode_ok = (prt_mode_e'(mode_req) == mode_q);
    assign is_shuf = (mode_q == MODE_SHUF);
    assign idle    = x_empty && s_empty;

    // Switch mode only once both paths hold no data.
    always_ff @(posedge clk) begin
        if (!rst_n)                 mode_q <= MODE_XPOSE;
        else if (idle && !mode_ok)  mode_q <= prt_mode_e'(mode_req);
    end

    prt_xpose_buf #(.LANES(LANES), .ELEM_W(ELEM_W)) i_xpose (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid && mode_ok && !is_shuf),
        .in_ready  (x_in_ready),
        .in_data   (in_data),
        .out_valid (x_out_valid),
        .out_ready (out_ready && !is_shuf),
        .out_data  (x_out_data),
        .empty     (x_empty)
    );

    prt_lane_shuffle #(.LANES(LANES), .ELEM_W(ELEM_W), .MASK_W(MASK_W)) i_shuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_we   (mask_we),
        .mask_in   (mask_in),
        .in_valid  (in_valid && mode_ok && is_shuf),
        .in_ready  (s_in_ready),
        .in_data   (in_data),
        .out_valid (s_out_valid),
        .out_ready (out_ready && is_shuf),
        .out_data  (s_out_data),
        .empty     (s_empty)
    );

    assign in_ready  = mode_ok && (is_shuf ? s_in_ready : x_in_ready);
    assign out_valid = is_shuf ? s_out_valid : x_out_valid;
    assign out_data  = is_shuf ? s_out_data : x_out_data;
endmodule

// File: rtl/prt_reorder_chk.sv
// Property checker for prt_reorder_unit, attached by bind.
// Counts transpose occupancy itself, so the capacity bound needs no deep $past.
module prt_reorder_chk #(
    parameter int LANES  = 32,
    parameter int ELEM_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [LANES*ELEM_W-1:0] out_data,
    input logic                    mode_q
);
    localparam int OW = $clog2(4 * LANES) + 1;
    logic [OW-1:0] occ;
    logic          in_fire, out_fire;

    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;

    // Track beats held in transpose mode.
    always_ff @(posedge clk) begin
        if (!rst_n) occ <= '0;
        else if (!mode_q) begin
            case ({in_fire, out_fire})
                2'b10:   occ <= occ + OW'(1);
                2'b01:   occ <= occ - OW'(1);
                default: occ <= occ;
            endcase
        end
    end

    // R3
    fill_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= OW'(2 * LANES));

    // R4
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R8
    shuf_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q && in_fire) |=> out_valid);

    // R10
    mode_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_q) |-> $past(!out_valid));
endmodule

bind prt_reorder_unit prt_reorder_chk #(.LANES(LANES), .ELEM_W(ELEM_W)) i_prt_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .mode_q    (mode_q)
);

// File: tb/test_prt_reorder_unit.sv
// Scoreboard bench: driver tasks queue expected beats, a monitor compares them.
module test_prt_reorder_unit;
    localparam int LANES = 32;
    localparam int EW    = 32;
    localparam int MW    = 8;
    localparam int DW    = LANES * EW;
    localparam int MDW   = LANES * MW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           mode_req = 1'b0;
    logic           mask_we = 1'b0;
    logic [MDW-1:0] mask_in = '0;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic [DW-1:0]  in_data = '0;
    logic           out_valid;
    logic           out_ready = 1'b1;
    logic [DW-1:0]  out_data;

    int checks = 0;
    int errors = 0;
    int acc_cnt = 0;
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];
    bit            hold = 1'b0;
    bit            bp_en = 1'b0;
    bit            timeout = 1'b0;
    bit            r3_done = 1'b0;
    logic [7:0]    lfsr = 8'h5b;

    prt_reorder_unit #(.LANES(LANES), .ELEM_W(EW), .MASK_W(MW)) i_prt_reorder_unit (
        .clk(clk), .rst_n(rst_n), .mode_req(mode_req), .mask_we(mask_we),
        .mask_in(mask_in), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data)
    );

    always #5 clk = ~clk;

    // Drive consumer back-pressure just after each rising edge.
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = hold ? 1'b0 : (bp_en ? (lfsr[0] | lfsr[3]) : 1'b1);
    end

    // Monitor: compare each accepted output beat with the queue head.
    always @(negedge clk) begin
        if (rst_n && in_valid && in_ready) acc_cnt++;
        if (rst_n && out_valid && out_ready) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL unexpected output beat: actual %h expected none", out_data[63:0]);
            end else begin
                logic [DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (out_data !== e) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h (low 64 bits)", t, out_data[63:0], e[63:0]);
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [EW-1:0] elem(input int t, input int b, input int l);
        return EW'(32'hA500_0000 ^ (t << 16) ^ (b << 8) ^ l);
    endfunction

    function automatic logic [DW-1:0] beat_of(input int t, input int b);
        logic [DW-1:0] v;
        for (int l = 0; l < LANES; l++) v[l*EW +: EW] = elem(t, b, l);
        return v;
    endfunction

    // Present one beat and wait until it is taken.
    task automatic put_beat(input logic [DW-1:0] d);
        bit r;
        in_data  = d;
        in_valid = 1'b1;
        do begin
            @(negedge clk);
            r = in_ready;
            @(posedge clk);
            #1;
        end while (!r);
        in_valid = 1'b0;
    endtask

    task automatic write_mask(input logic [MDW-1:0] m);
        mask_in = m;
        mask_we = 1'b1;
        @(posedge clk);
        #1;
        mask_we = 1'b0;
    endtask

    // R2: queue the transposed rows of tile t, then drive its columns.
    task automatic send_xpose(input int t);
        for (int k = 0; k < LANES; k++) begin
            logic [DW-1:0] v;
            for (int q = 0; q < LANES; q++) v[q*EW +: EW] = elem(t, q, k);
            exp_q.push_back(v);
            tag_q.push_back("R2 transpose row");
        end
        for (int b = 0; b < LANES; b++) put_beat(beat_of(t, b));
    endtask

    // R5: queue routed beats under mask m; optionally write mask nm before beat mid_at.
    task automatic send_shuf(input int t, input logic [MDW-1:0] m, input string tag,
                             input bit mid, input int mid_at, input logic [MDW-1:0] nm);
        for (int b = 0; b < LANES; b++) begin
            logic [DW-1:0] v;
            for (int i = 0; i < LANES; i++)
                v[i*EW +: EW] = elem(t, b, int'(m[i*MW +: MW]) % LANES);
            exp_q.push_back(v);
            tag_q.push_back(tag);
        end
        for (int b = 0; b < LANES; b++) begin
            if (mid && b == mid_at) begin
                mask_in = nm;
                mask_we = 1'b1;
            end
            put_beat(beat_of(t, b));
            mask_we = 1'b0;
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        fork
            begin : tests
                logic [MDW-1:0] m_id, m_mod, m_rev, m_zero, m_b5;
                int base;
                time t0;
                for (int i = 0; i < LANES; i++) begin
                    m_id[i*MW +: MW]   = MW'(i);
                    m_mod[i*MW +: MW]  = MW'(i + 32);
                    m_rev[i*MW +: MW]  = MW'((LANES - 1 - i) + ((i % 2) ? 64 : 0));
                    m_zero[i*MW +: MW] = '0;
                    m_b5[i*MW +: MW]   = MW'(5 + 96);
                end
                repeat (5) @(posedge clk);
                #1 rst_n = 1'b1;
                @(negedge clk);
                check(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'd0);
                check(in_ready == 1'b1, "R1 in_ready after reset", 64'(in_ready), 64'd1);
                @(posedge clk); #1;

                // R2: back-to-back tiles, then under random back-pressure
                send_xpose(1);
                send_xpose(2);
                drain();
                bp_en = 1'b1;
                send_xpose(3);
                send_xpose(4);
                drain();
                bp_en = 1'b0;

                // R3: both stores fill while output is blocked
                hold = 1'b1;
                base = acc_cnt;
                fork
                    begin
                        send_xpose(5);
                        send_xpose(6);
                        send_xpose(7);
                        r3_done = 1'b1;
                    end
                join_none
                repeat (100) @(posedge clk);
                #1;
                check(acc_cnt - base == 64, "R3 beats accepted while blocked", 64'(acc_cnt - base), 64'd64);
                check(in_ready == 1'b0, "R3 in_ready with both stores full", 64'(in_ready), 64'd0);
                hold = 1'b0;
                wait (r3_done);
                @(posedge clk); #1;
                drain();

                // R10: mode request while a tile is still held
                hold = 1'b1;
                send_xpose(8);
                mode_req = 1'b1;
                repeat (5) @(posedge clk);
                @(negedge clk);
                check(in_ready == 1'b0, "R10 in_ready while old mode drains", 64'(in_ready), 64'd0);
                check(out_valid == 1'b1, "R10 held tile still offered", 64'(out_valid), 64'd1);
                @(posedge clk); #1;
                hold = 1'b0;
                drain();
                check(in_ready == 1'b1, "R10 in_ready after switch", 64'(in_ready), 64'd1);

                // R7: identity mask, then entries offset by 32
                write_mask(m_id);
                send_shuf(10, m_id, "R7 identity", 1'b0, 0, '0);
                drain();
                write_mask(m_mod);
                send_shuf(11, m_mod, "R7 modulo identity", 1'b0, 0, '0);
                drain();

                // R5: reversed mask with wrapped entries
                write_mask(m_rev);
                send_shuf(12, m_rev, "R5 reversed routing", 1'b0, 0, '0);
                drain();

                // R6: broadcast of lane 0
                write_mask(m_zero);
                send_shuf(13, m_zero, "R6 broadcast", 1'b0, 0, '0);
                drain();

                // R8: full throughput and single-register latency
                t0 = $time;
                send_shuf(14, m_zero, "R8 stream", 1'b0, 0, '0);
                check(($time - t0) == 320, "R8 cycles for 32 beats", 64'(($time - t0) / 10), 64'd32);
                check(out_valid == 1'b1 && exp_q.size() == 1, "R8 last beat one cycle late",
                      64'(exp_q.size()), 64'd1);
                drain();

                // R9: mask written mid-tile applies from the next tile
                write_mask(m_id);
                send_shuf(15, m_id, "R9 tile keeps its mask", 1'b1, 10, m_b5);
                send_shuf(16, m_b5, "R9 next tile uses new mask", 1'b0, 0, '0);
                drain();

                // R4: shuffle under back-pressure
                write_mask(m_rev);
                bp_en = 1'b1;
                send_shuf(17, m_rev, "R4 hold under stall", 1'b0, 0, '0);
                send_shuf(18, m_rev, "R4 hold under stall", 1'b0, 0, '0);
                drain();
                bp_en = 1'b0;

                // R10: back to transpose once idle
                mode_req = 1'b0;
                send_xpose(19);
                drain();

                check(exp_q.size() == 0, "R2 all expected beats seen", 64'(exp_q.size()), 64'd0);
            end
            begin : watchdog
                repeat (150000) @(posedge clk);
                timeout = 1'b1;
            end
        join_any
        if (timeout) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule